// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is an SPI master peripheral that software drives through a small 32-bit register bus with separate read and write strobes. Software first writes a command word. The command word sets the word length, the clock polarity and phase, which directions are active and how the four chip-select lines behave. Software then loads up to four transmit words into a FIFO port and writes a transfer-control word. That word holds a block count and a start bit.

The shift engine moves the programmed number of words, MSB first. Each word is 1 to 32 bits long. The engine waits at a word boundary whenever the transmit FIFO has nothing to send or the receive FIFO has no room, so software can feed and drain the FIFOs while a block is running. When the last word is done, busy falls and a ready flag rises. A completion interrupt follows if it is enabled for an active direction. Software clears the ready and error flags by writing ones to them.

The serial clock runs at a fixed division of the system clock. Each half period lasts `CLK_DIV` system cycles.

Top module: `spi_reg_master`

## Requirements
- R1: After reset the status register reads 0x0280_0000 (only the two FIFO-empty flags set), all chip-select pins are high, SCLK is low and the interrupt is low.
- R2: Command bits [4:0] hold the word length minus one. Each word shifts MSB first from the low bits of its transmit entry. Each received word is stored right-aligned, with the upper bits zero.
- R3: Command bit 26 sets the idle SCLK level (1 means high). Command bit 21 selects the phase. When bit 21 is clear, data is sampled on the leading edge and changed on the trailing edge. When bit 21 is set, data is changed on the leading edge and sampled on the trailing edge.
- R4: Transfer-control bits [15:0] hold the word count minus one, and a write with bit 31 set starts the transfer. Exactly that many words are shifted. Status bit 31 (busy) is high for the whole transfer. Status bit 30 (ready) is set in the cycle in which busy falls.
- R5: Each FIFO holds four words. Status bits 22 and 23 report the transmit FIFO as full and empty. Status bits 24 and 25 report the receive FIFO as full and empty.
- R6: A write to the transmit port (offset 0x10) while the transmit FIFO is full is discarded and sets status bit 26.
- R7: A read of the receive port (offset 0x20) while the receive FIFO is empty returns zero and sets status bit 27.
- R8: Writing 1 to status bit 30, 26 or 27 clears that bit, and writing 0 leaves it unchanged.
- R9: The interrupt is high exactly when ready is set and one of these holds: transfer-control bit 26 is set with transmit enabled (command bit 15), or transfer-control bit 27 is set with receive enabled (command bit 14).
- R10: Command bits 5 to 8 enable chip-select pins 0 to 3, and a disabled pin rests at its inactive level. With command bit 12 clear, an enabled pin is active only while busy. The active level is low, or high when command bit 16 is set. With bit 12 set, an enabled pin follows command bit 13 directly.
- R11: At a word boundary the engine holds busy and an idle SCLK while transmit is enabled and the transmit FIFO is empty. It also holds while receive is enabled and the receive FIFO is full. It resumes once the FIFO condition clears.
- R12: Writes to the command and transfer-control registers are ignored while busy. Transfer-control bit 31 reads back as busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; pops the receive FIFO at offset 0x20 |
| bus_rdata | output | 32 | Read data for the addressed register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_pin | output | 4 | Chip-select pins |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check these properties on every cycle:
- the FIFOs are never pushed when full or popped when empty, whether by the bus or by the engine;
- the shift position never runs past the programmed word length;
- ready rises in the same cycle that busy falls;
- the interrupt never rises without ready;
- the command fields stay frozen while busy.

The properties the bench has to show through scenarios are these:
- bit order and edge choice for each clock mode, which a scoreboard checks by decoding MOSI independently;
- right alignment of received words;
- the exact word count;
- chip-select levels in both control styles;
- the stall and resume behaviour around an empty transmit FIFO or a full receive FIFO.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;

    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_XCTL = 8'h0C;
    localparam logic [7:0] OFS_TXP  = 8'h10;
    localparam logic [7:0] OFS_RXP  = 8'h20;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOAD,
        ENG_SHIFT
    } eng_state_e;

    typedef struct packed {
        logic       clk_idle_hi;
        logic       late_phase;
        logic       tx_on;
        logic       rx_on;
        logic       sel_invert;
        logic       sel_manual;
        logic       sel_level;
        logic [3:0] sel_en;
        logic [4:0] len_m1;
    } spi_cmd_t;

    function automatic logic [31:0] cmd_pack(spi_cmd_t c);
        logic [31:0] w;
        w       = '0;
        w[4:0]  = c.len_m1;
        w[8:5]  = c.sel_en;
        w[12]   = c.sel_manual;
        w[13]   = c.sel_level;
        w[14]   = c.rx_on;
        w[15]   = c.tx_on;
        w[16]   = c.sel_invert;
        w[21]   = c.late_phase;
        w[26]   = c.clk_idle_hi;
        return w;
    endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wp;
        logic [PTR_W-1:0]            rp;
        logic [CNT_W-1:0]            cnt;
    } fifo_t;

    fifo_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (push) begin
            f_d.mem[f_q.wp] = wdata;
            f_d.wp = (f_q.wp == PTR_LAST) ? '0 : f_q.wp + 1'b1;
        end
        if (pop) begin
            f_d.rp = (f_q.rp == PTR_LAST) ? '0 : f_q.rp + 1'b1;
        end
        if (push && !pop) begin
            f_d.cnt = f_q.cnt + 1'b1;
        end else if (pop && !push) begin
            f_d.cnt = f_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign rdata = f_q.mem[f_q.rp];
    assign full  = (f_q.cnt == CNT_FULL);
    assign empty = (f_q.cnt == '0);

    // R6: the writer never pushes into a full FIFO
    p_push_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7: the reader never pops an empty FIFO
    p_pop_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_ctrl_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  spi_cmd_t         cfg,
    input  logic             start,
    input  logic [CNT_W-1:0] blk_m1,
    input  logic [31:0]      tx_data,
    input  logic             tx_empty,
    input  logic             rx_full,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [31:0]      rx_word,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    typedef struct packed {
        eng_state_e       st;
        logic             sclk;
        logic             mosi;
        logic [31:0]      tx_sh;
        logic [31:0]      rx_sh;
        logic [5:0]       half;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] left;
    } eng_t;

    eng_t e_d, e_q;
    logic        lead;
    logic        hold;
    logic [31:0] word_mask;

    assign word_mask = 32'hFFFF_FFFF >> (5'd31 - cfg.len_m1);
    assign hold      = (cfg.tx_on && tx_empty) || (cfg.rx_on && rx_full);

    always_comb begin
        e_d     = e_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_word = '0;
        done    = 1'b0;
        lead    = 1'b0;
        case (e_q.st)
            ENG_IDLE: begin
                e_d.sclk = cfg.clk_idle_hi;
                e_d.mosi = 1'b0;
                if (start) begin
                    e_d.left = blk_m1;
                    e_d.st   = ENG_LOAD;
                end
            end
            ENG_LOAD: begin
                if (!hold) begin
                    tx_pop    = cfg.tx_on;
                    e_d.tx_sh = (cfg.tx_on ? tx_data : 32'h0) << (5'd31 - cfg.len_m1);
                    e_d.half  = '0;
                    e_d.div   = '0;
                    e_d.st    = ENG_SHIFT;
                    if (!cfg.late_phase) begin
                        e_d.mosi  = e_d.tx_sh[31];
                        e_d.tx_sh = e_d.tx_sh << 1;
                    end
                end
            end
            ENG_SHIFT: begin
                if (e_q.div == DIV_LAST) begin
                    e_d.div  = '0;
                    e_d.sclk = ~e_q.sclk;
                    lead     = ~e_q.half[0];
                    if (lead != cfg.late_phase) begin
                        e_d.rx_sh = {e_q.rx_sh[30:0], miso};
                    end else begin
                        e_d.mosi  = e_q.tx_sh[31];
                        e_d.tx_sh = e_q.tx_sh << 1;
                    end
                    e_d.half = e_q.half + 6'd1;
                    if (e_q.half == {cfg.len_m1, 1'b1}) begin
                        rx_push = cfg.rx_on;
                        rx_word = e_d.rx_sh & word_mask;
                        if (e_q.left == '0) begin
                            e_d.st = ENG_IDLE;
                            done   = 1'b1;
                        end else begin
                            e_d.left = e_q.left - 1'b1;
                            e_d.st   = ENG_LOAD;
                        end
                    end
                end else begin
                    e_d.div = e_q.div + 1'b1;
                end
            end
            default: e_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy = (e_q.st != ENG_IDLE);
    assign sclk = e_q.sclk;
    assign mosi = e_q.mosi;

    // R11: a word only starts with data available and room to store it
    p_pop_has_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);
    p_push_has_room_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
    // R2: shift position stays inside the programmed word
    p_half_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ENG_SHIFT) |-> (e_q.half <= {cfg.len_m1, 1'b1}));

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
    import spi_ctrl_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CLK_DIV    = 2,
    parameter int CNT_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  cs_pin,
    output logic        irq
);
    localparam int NUM_CS = 4;

    typedef struct packed {
        spi_cmd_t         cmd;
        logic [CNT_W-1:0] blk_m1;
        logic             ie_tx;
        logic             ie_rx;
        logic             ready;
        logic             tx_ovf;
        logic             rx_unf;
    } regs_t;

    regs_t r_d, r_q;

    logic        eng_busy, eng_done;
    logic        start, tx_push, rx_pop, tx_pop, rx_push;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic [31:0] tx_data, rx_data, rx_word;

    always_comb begin
        r_d     = r_q;
        start   = 1'b0;
        tx_push = 1'b0;
        rx_pop  = 1'b0;
        if (bus_wr && bus_addr == OFS_CMD && !eng_busy) begin
            r_d.cmd.len_m1      = bus_wdata[4:0];
            r_d.cmd.sel_en      = bus_wdata[8:5];
            r_d.cmd.sel_manual  = bus_wdata[12];
            r_d.cmd.sel_level   = bus_wdata[13];
            r_d.cmd.rx_on       = bus_wdata[14];
            r_d.cmd.tx_on       = bus_wdata[15];
            r_d.cmd.sel_invert  = bus_wdata[16];
            r_d.cmd.late_phase  = bus_wdata[21];
            r_d.cmd.clk_idle_hi = bus_wdata[26];
        end
        if (bus_wr && bus_addr == OFS_XCTL && !eng_busy) begin
            r_d.blk_m1 = bus_wdata[CNT_W-1:0];
            r_d.ie_tx  = bus_wdata[26];
            r_d.ie_rx  = bus_wdata[27];
            start      = bus_wdata[31];
        end
        if (bus_wr && bus_addr == OFS_STAT) begin
            if (bus_wdata[30]) r_d.ready  = 1'b0;
            if (bus_wdata[26]) r_d.tx_ovf = 1'b0;
            if (bus_wdata[27]) r_d.rx_unf = 1'b0;
        end
        if (start) begin
            r_d.ready = 1'b0;
        end
        if (bus_wr && bus_addr == OFS_TXP) begin
            if (tx_full) r_d.tx_ovf = 1'b1;
            else         tx_push    = 1'b1;
        end
        if (bus_rd && bus_addr == OFS_RXP) begin
            if (rx_empty) r_d.rx_unf = 1'b1;
            else          rx_pop     = 1'b1;
        end
        if (eng_done) begin
            r_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CMD:  bus_rdata = cmd_pack(r_q.cmd);
            OFS_STAT: bus_rdata = {eng_busy, r_q.ready, 2'b00, r_q.rx_unf, r_q.tx_ovf,
                                   rx_empty, rx_full, tx_empty, tx_full, 22'd0};
            OFS_XCTL: begin
                bus_rdata[31]          = eng_busy;
                bus_rdata[27]          = r_q.ie_rx;
                bus_rdata[26]          = r_q.ie_tx;
                bus_rdata[CNT_W-1:0]   = r_q.blk_m1;
            end
            OFS_RXP:  bus_rdata = rx_empty ? 32'h0 : rx_data;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = r_q.ready && ((r_q.ie_tx && r_q.cmd.tx_on) || (r_q.ie_rx && r_q.cmd.rx_on));

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_pin[i] = !r_q.cmd.sel_en[i] ? ~r_q.cmd.sel_invert :
                           r_q.cmd.sel_manual ? r_q.cmd.sel_level :
                           (eng_busy ? r_q.cmd.sel_invert : ~r_q.cmd.sel_invert);
    end

    spi_word_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (bus_wdata),
        .pop   (tx_pop),
        .rdata (tx_data),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_word_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (rx_pop),
        .rdata (rx_data),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_shift_engine #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (r_q.cmd),
        .start    (start),
        .blk_m1   (bus_wdata[CNT_W-1:0]),
        .tx_data  (tx_data),
        .tx_empty (tx_empty),
        .rx_full  (rx_full),
        .tx_pop   (tx_pop),
        .rx_push  (rx_push),
        .rx_word  (rx_word),
        .busy     (eng_busy),
        .done     (eng_done),
        .sclk     (sclk),
        .mosi     (mosi),
        .miso     (miso)
    );

    // R4: completion raises ready as busy drops
    p_ready_at_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_busy) |-> r_q.ready);
    // R9: no interrupt without ready
    p_irq_needs_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> r_q.ready);
    // R12: command fields frozen during a transfer
    p_cmd_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> $stable(r_q.cmd));

endmodule

// File: tb/spi_reg_master_bench.sv
module spi_reg_master_bench;

    localparam logic [7:0] A_CMD = 8'h00, A_STAT = 8'h04, A_XCTL = 8'h0C,
                           A_TXP = 8'h10, A_RXP = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_pin;
    logic        irq;
    logic        miso_hi = 1'b0;

    always #5 clk = ~clk;
    assign miso = miso_hi ? 1'b1 : mosi;

    spi_reg_master u_spi_reg_master (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_pin(cs_pin), .irq(irq)
    );

    int n_vec = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    logic        mon_en = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;
    int          m_len = 8, nb = 0;
    logic [31:0] bits_got = '0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] lmask(input int len);
        return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
    endfunction

    function automatic logic [31:0] mkcmd(input logic cpol, input logic cpha, input int len,
                                          input logic tx, input logic rx, input logic [3:0] en,
                                          input logic sw, input logic lvl, input logic inv);
        logic [31:0] w = '0;
        w[4:0] = 5'(len - 1); w[8:5] = en; w[12] = sw; w[13] = lvl;
        w[14] = rx; w[15] = tx; w[16] = inv; w[21] = cpha; w[26] = cpol;
        return w;
    endfunction

    // scoreboard monitor: decode MOSI on the sampling edge of the selected mode (R2, R3)
    always @(sclk) begin
        if (mon_en && (((sclk !== m_cpol) ? 1'b1 : 1'b0) != m_cpha)) begin
            bits_got = {bits_got[30:0], mosi};
            nb++;
            if (nb == m_len) begin
                n_vec++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R4 extra shifted word got %h exp none", bits_got);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    if ((bits_got & lmask(m_len)) !== e) begin
                        n_bad++;
                        $display("FAIL R3 shifted word got %h exp %h", bits_got & lmask(m_len), e);
                    end
                end
                nb = 0;
                bits_got = '0;
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic setup(input logic [31:0] cmd, input logic mon);
        mon_en = 1'b0;
        wr(A_CMD, cmd);
        repeat (3) @(negedge clk);
        m_cpol = cmd[26]; m_cpha = cmd[21]; m_len = int'(cmd[4:0]) + 1;
        nb = 0; bits_got = '0;
        mon_en = mon;
    endtask

    task automatic send(input logic [31:0] w);
        exp_q.push_back(w & lmask(m_len));
        wr(A_TXP, w);
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(A_STAT, s);
            if (!s[31]) return;
        end
        chk("R4 transfer never finished", s[31], 1'b0);
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R4 watchdog got hang exp completion");
        finish_up();
    end

    initial begin
        logic [31:0] v, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(A_STAT, v);
        chk("R1 status", v, 32'h0280_0000);
        chk("R1 cs", cs_pin, 4'hF);
        chk("R1 sclk", sclk, 1'b0);
        chk("R1 irq", irq, 1'b0);

        // mode 0, 8-bit, three words, cs0 hardware
        setup(mkcmd(0, 0, 8, 1, 1, 4'b0001, 0, 0, 0), 1'b1);
        chk("R3 idle low", sclk, 1'b0);
        send(32'h0000_00A5); send(32'h0000_003C); send(32'h1234_5601);
        wr(A_XCTL, 32'h8400_0002);
        rd(A_STAT, v);
        chk("R4 busy", v[31], 1'b1);
        chk("R10 hw cs active low", cs_pin, 4'b1110);
        wait_done();
        chk("R4 all words shifted", exp_q.size(), 0);
        rd(A_STAT, v);
        chk("R4 ready status", v, 32'h4080_0000);
        chk("R9 irq tx enable", irq, 1'b1);
        chk("R10 cs released", cs_pin, 4'hF);
        rd(A_RXP, v); chk("R2 rx word0", v, 32'hA5);
        rd(A_RXP, v); chk("R2 rx word1", v, 32'h3C);
        rd(A_RXP, v); chk("R2 rx word2", v, 32'h01);
        rd(A_RXP, v); chk("R7 empty read zero", v, 32'h0);
        rd(A_STAT, v); chk("R7 underflow flag", v, 32'h4A80_0000);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R8 zero write keeps", v, 32'h4A80_0000);
        wr(A_STAT, 32'h4C00_0000);
        rd(A_STAT, v); chk("R8 one write clears", v, 32'h0280_0000);
        chk("R9 irq after clear", irq, 1'b0);

        // mode 3, 12-bit, inverted cs2
        setup(mkcmd(1, 1, 12, 1, 1, 4'b0100, 0, 0, 1), 1'b1);
        chk("R3 idle high", sclk, 1'b1);
        chk("R10 inverted idle", cs_pin, 4'b0000);
        send(32'hABCD_E5A5); send(32'h0000_0FFF);
        wr(A_XCTL, 32'h8800_0001);
        rd(A_STAT, v);
        chk("R10 inverted active", cs_pin, 4'b0100);
        wait_done();
        chk("R9 irq rx enable", irq, 1'b1);
        rd(A_RXP, v); chk("R2 rx 12-bit a", v, 32'h5A5);
        rd(A_RXP, v); chk("R2 rx 12-bit b", v, 32'hFFF);
        chk("R4 mode3 words", exp_q.size(), 0);
        wr(A_STAT, 32'h4C00_0000);

        // mode 1 and mode 2, one 32-bit word each
        setup(mkcmd(0, 1, 32, 1, 1, 4'b0001, 0, 0, 0), 1'b1);
        send(32'hDEAD_BEEF);
        wr(A_XCTL, 32'h8000_0000);
        wait_done();
        rd(A_RXP, v); chk("R3 mode1 rx", v, 32'hDEAD_BEEF);
        setup(mkcmd(1, 0, 32, 1, 1, 4'b0001, 0, 0, 0), 1'b1);
        send(32'h8000_0001);
        wr(A_XCTL, 32'h8000_0000);
        wait_done();
        rd(A_RXP, v); chk("R3 mode2 rx", v, 32'h8000_0001);
        chk("R4 single words", exp_q.size(), 0);

        // one-bit words
        setup(mkcmd(0, 0, 1, 1, 1, 4'b0001, 0, 0, 0), 1'b1);
        send(32'hFFFF_FFFF); send(32'hFFFF_FFFE); send(32'h3); send(32'h5);
        wr(A_XCTL, 32'h8000_0003);
        wait_done();
        rd(A_RXP, v); chk("R2 1-bit a", v, 32'h1);
        rd(A_RXP, v); chk("R2 1-bit b", v, 32'h0);
        rd(A_RXP, v); chk("R2 1-bit c", v, 32'h1);
        rd(A_RXP, v); chk("R2 1-bit d", v, 32'h1);
        wr(A_STAT, 32'h4C00_0000);

        // transmit-only, overflow
        setup(mkcmd(0, 0, 8, 1, 0, 4'b0010, 0, 0, 0), 1'b1);
        send(32'h11); send(32'h22); send(32'h33); send(32'h44);
        rd(A_STAT, v); chk("R5 tx full", v, 32'h0240_0000);
        wr(A_TXP, 32'h55);
        rd(A_STAT, v); chk("R6 overflow flag", v, 32'h0640_0000);
        wr(A_XCTL, 32'h8800_0003);
        rd(A_STAT, v);
        chk("R10 cs1 active", cs_pin, 4'b1101);
        wait_done();
        chk("R6 discarded word not sent", exp_q.size(), 0);
        rd(A_STAT, v); chk("R2 rx off nothing stored", v, 32'h4680_0000);
        chk("R9 irq rx enable but rx off", irq, 1'b0);
        wr(A_STAT, 32'h4C00_0000);

        // stall on empty transmit FIFO, writes ignored while busy
        setup(mkcmd(0, 0, 8, 1, 0, 4'b0001, 0, 0, 0), 1'b1);
        rd(A_CMD, c);
        wr(A_XCTL, 32'h8000_0001);
        repeat (20) @(negedge clk);
        rd(A_STAT, v); chk("R11 stalled busy", v[31], 1'b1);
        chk("R11 sclk idle while stalled", sclk, 1'b0);
        rd(A_XCTL, v); chk("R12 go reads busy", v, 32'h8000_0001);
        wr(A_CMD, mkcmd(1, 1, 16, 0, 1, 4'b1000, 0, 0, 1));
        wr(A_XCTL, 32'h8C00_00FF);
        rd(A_CMD, v); chk("R12 command kept", v, c);
        rd(A_XCTL, v); chk("R12 xctl kept", v, 32'h8000_0001);
        send(32'h96); send(32'h69);
        wait_done();
        chk("R11 resumed words", exp_q.size(), 0);
        wr(A_STAT, 32'h4C00_0000);

        // stall on full receive FIFO, receive-only
        miso_hi = 1'b1;
        setup(mkcmd(0, 0, 8, 0, 1, 4'b0001, 0, 0, 0), 1'b0);
        wr(A_XCTL, 32'h8000_0005);
        for (int i = 0; i < 400; i++) begin
            rd(A_STAT, v);
            if (v[24]) break;
        end
        repeat (40) @(negedge clk);
        rd(A_STAT, v); chk("R11 rx full stall", v, 32'h8180_0000);
        for (int i = 0; i < 4; i++) begin
            rd(A_RXP, v); chk("R2 rx-only upper zero", v, 32'hFF);
        end
        wait_done();
        for (int i = 0; i < 2; i++) begin
            rd(A_RXP, v); chk("R11 rx after resume", v, 32'hFF);
        end
        miso_hi = 1'b0;
        wr(A_STAT, 32'h4C00_0000);

        // software chip select
        setup(mkcmd(0, 0, 8, 1, 1, 4'b0010, 1, 0, 0), 1'b0);
        chk("R10 sw low", cs_pin, 4'b1101);
        setup(mkcmd(0, 0, 8, 1, 1, 4'b0010, 1, 1, 0), 1'b0);
        chk("R10 sw high", cs_pin, 4'b1111);
        setup(mkcmd(0, 0, 8, 1, 1, 4'b0010, 1, 1, 1), 1'b0);
        chk("R10 sw inverted", cs_pin, 4'b0010);

        finish_up();
    end

endmodule